// File: doc/BRIEF.md
# Adaptive PROM Program-Verify Sequencer

This block drives the pins of a one-time-programmable memory from the host side and burns a stream of bytes into it, one location after another. The device has no address pins. The block picks its operation through four mode pins, moves to the next location with four pulses on a clock pin, and trades data over a byte-wide bus made of two nibbles. Two enables ask the board to raise the low supply and the high programming supply. The supplies themselves are outside the block.

After a start command the block waits for the part to settle. It clears the device address and raises the supplies in order. For each byte it repeats a write pulse, an inhibit gap and a read-back until the read data matches. It then adds one reinforcing write, whose length is the base write time multiplied by the number of writes that byte needed, and steps the address. A byte flagged as last closes the session. A byte that still mismatches after the retry limit ends the session with a fail status and leaves its address on a port. Every interval comes from a cycle count derived from the clock frequency parameter.

Top module: `prom_pv_seq`

## Requirements
- R1: After reset and while idle, both supply enables, the data drive enable and the address clock are low, busy is low, src_ready_o is low and the mode pins read 4'b0000.
- R2: After start_i the block holds the idle mode with the supplies off for SETTLE_US. It then shows clear-address mode for SETUP_US before the low-supply enable rises. Mode encodings are given on mode_o[3:0] with bit 0 as the first mode pin: clear 4'b0101, write 4'b1110, verify 4'b1100, inhibit 4'b1101.
- R3: The high-supply enable is only ever high while the low-supply enable is high. It rises SETUP_US after the low enable and falls SETUP_US before it. Clear-address mode is shown whenever either enable changes.
- R4: Each ordinary write holds write mode for WR_US with the byte driven. The bus is driven in inhibit mode for SETUP_US before and after each write, and write mode is only ever left towards inhibit.
- R5: Verify mode releases the bus. The byte read back at the end of the SETUP_US verify window is compared with the byte being programmed. On a mismatch the block runs inhibit, write, inhibit and verify again.
- R6: After a match, one extra write is applied whose length is WR_US multiplied by the number of ordinary writes made for that byte. No verify follows it.
- R7: After the extra write the address clock gives exactly four high pulses while the mode is inhibit and the bus is released. The next byte is then taken from the source.
- R8: The number of ordinary writes per byte never exceeds MAX_TRIES. A mismatch on the MAX_TRIES-th verify sets fail_o and leaves the failing byte's index, counted from 0 per session, on fail_addr_o. The session then shuts down through the normal power-down path. fail_o stays until the next start.
- R9: A byte accepted with src_last_i ends the session after its address step. The block shows clear mode, drops the high supply, then the low supply, and pulses done_o for one cycle as busy_o falls.
- R10: When the stored data equals the byte after the first write, the byte completes with one ordinary write and a reinforcing write of WR_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | begin a programming session (ignored while busy) |
| src_valid_i | input | 1 | source byte available |
| src_data_i | input | DATA_W | byte to program |
| src_last_i | input | 1 | marks the final byte of the session |
| src_ready_o | output | 1 | block takes the byte this cycle when valid |
| mode_o | output | 4 | mode-select pins of the device |
| xclk_o | output | 1 | address-advance clock pin |
| dat_o | output | DATA_W | data towards the device (low and high nibble) |
| dat_oe_o | output | 1 | drive enable for dat_o |
| dat_i | input | DATA_W | data read back from the device |
| vdd_prog_o | output | 1 | request for the raised low supply |
| vpp_prog_o | output | 1 | request for the high programming supply |
| busy_o | output | 1 | session in progress |
| done_o | output | 1 | one-cycle pulse at session end |
| fail_o | output | 1 | last session aborted at the retry limit |
| fail_addr_o | output | ADDR_W | index of the current (on abort: failing) byte |

## Verification
The bench builds the block with CLK_HZ of 1 MHz, so one cycle stands for one microsecond. It uses a 20 µs base write, a 10 µs settle, a 2 µs setup, a retry limit of 4 and one input synchronizer stage. With those values a whole session fits in a few thousand cycles. The settle, setup and pulse lengths can be counted exactly, and a byte needing exactly the limit, a byte that matches at once, and a byte that runs past the limit all come within reach. A pin-level model of the memory counts the writes, the pulse lengths and the address-clock edges.

// File: rtl/prom_pv_pkg.sv
package prom_pv_pkg;

   // mode pin codes, bit 0 = first mode pin
   localparam logic [3:0] PM_IDLE    = 4'b0000;
   localparam logic [3:0] PM_CLEAR   = 4'b0101;
   localparam logic [3:0] PM_WRITE   = 4'b1110;
   localparam logic [3:0] PM_VERIFY  = 4'b1100;
   localparam logic [3:0] PM_INHIBIT = 4'b1101;

   typedef enum logic [3:0] {
      ST_IDLE, ST_SETTLE, ST_CLR, ST_VDDUP, ST_VPPUP, ST_INH, ST_FETCH,
      ST_DSET, ST_WR, ST_WHLD, ST_VFY, ST_STEP, ST_FCLR, ST_VPPDN, ST_VDDDN
   } pv_state_e;

   typedef struct packed {
      logic [3:0] mode;
      logic       oe;
      logic       vdd;
      logic       vpp;
   } pin_set_t;

   function automatic pin_set_t pins_of(pv_state_e s);
      pin_set_t p;
      p.oe  = (s == ST_DSET) || (s == ST_WR) || (s == ST_WHLD);
      p.vpp = (s != ST_IDLE) && (s != ST_SETTLE) && (s != ST_CLR) &&
              (s != ST_VDDUP) && (s != ST_VPPDN) && (s != ST_VDDDN);
      p.vdd = p.vpp || (s == ST_VDDUP) || (s == ST_VPPDN);
      case (s)
         ST_CLR, ST_VDDUP, ST_VPPUP,
         ST_FCLR, ST_VPPDN, ST_VDDDN:     p.mode = PM_CLEAR;
         ST_INH, ST_FETCH, ST_DSET,
         ST_WHLD, ST_STEP:                p.mode = PM_INHIBIT;
         ST_WR:                           p.mode = PM_WRITE;
         ST_VFY:                          p.mode = PM_VERIFY;
         default:                         p.mode = PM_IDLE;
      endcase
      return p;
   endfunction

   function automatic logic is_timed(pv_state_e s);
      return (s != ST_IDLE) && (s != ST_FETCH) && (s != ST_STEP);
   endfunction

endpackage

// File: rtl/pv_timer.sv
module pv_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R2
   load_when_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> zero);

endmodule

// File: rtl/pv_stepper.sv
module pv_stepper #(
   parameter int HALF = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic xclk,
   output logic fin
);
   localparam int HW = $clog2(HALF + 1);
   localparam logic [HW-1:0] HALF_M1 = HW'(HALF - 1);

   logic          active_q;
   logic [2:0]    phase_q;
   logic [HW-1:0] hcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         phase_q  <= '0;
         hcnt_q   <= '0;
      end else if (go) begin
         active_q <= 1'b1;
         phase_q  <= '0;
         hcnt_q   <= HALF_M1;
      end else if (active_q) begin
         if (hcnt_q == '0) begin
            hcnt_q <= HALF_M1;
            if (phase_q == 3'd7) active_q <= 1'b0;
            else                 phase_q  <= phase_q + 3'd1;
         end else begin
            hcnt_q <= hcnt_q - 1'b1;
         end
      end
   end

   // even phases high: four pulses, ending low
   assign xclk = active_q && !phase_q[0];
   assign fin  = active_q && (hcnt_q == '0) && (phase_q == 3'd7);

   // R7
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !active_q);

endmodule

// File: rtl/prom_pv_seq.sv
module prom_pv_seq
   import prom_pv_pkg::*;
#(
   parameter int CLK_HZ      = 250_000_000,
   parameter int WR_US       = 1000,
   parameter int SETTLE_US   = 10,
   parameter int SETUP_US    = 2,
   parameter int MAX_TRIES   = 25,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              src_valid_i,
   input  logic [DATA_W-1:0] src_data_i,
   input  logic              src_last_i,
   output logic              src_ready_o,
   output logic [3:0]        mode_o,
   output logic              xclk_o,
   output logic [DATA_W-1:0] dat_o,
   output logic              dat_oe_o,
   input  logic [DATA_W-1:0] dat_i,
   output logic              vdd_prog_o,
   output logic              vpp_prog_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic [ADDR_W-1:0] fail_addr_o
);
   localparam int CYC_US     = CLK_HZ / 1_000_000;
   localparam int WR_CYC     = WR_US * CYC_US;
   localparam int SETTLE_CYC = SETTLE_US * CYC_US;
   localparam int SETUP_CYC  = SETUP_US * CYC_US;
   localparam int LONGEST    = (WR_CYC * MAX_TRIES > SETTLE_CYC) ?
                               WR_CYC * MAX_TRIES : SETTLE_CYC;
   localparam int TW         = $clog2(LONGEST + 1);
   localparam int TRW        = $clog2(MAX_TRIES + 1);
   localparam logic [TRW-1:0] MAX_T = TRW'(MAX_TRIES);

   // elaboration-time parameter checks
   if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
      $error("CLK_HZ must be a whole number of MHz");
   end
   if (SETUP_CYC <= SYNC_STAGES) begin : g_bad_sync
      $error("setup window must outlast the read-back synchronizer");
   end
   if (MAX_TRIES < 1 || WR_US < 1 || SETTLE_US < 1) begin : g_bad_cnt
      $error("retry limit and intervals must be at least 1");
   end
   if ((DATA_W % 4) != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of nibbles");
   end

   pv_state_e         st_q, st_d;
   pin_set_t          pins_q;
   logic [DATA_W-1:0] byte_q;
   logic              last_q, extra_q, fail_q, done_q;
   logic [TRW-1:0]    tries_q;
   logic [ADDR_W-1:0] addr_q;
   logic              tmr_load, tmr_zero, step_go, step_fin, match;
   logic [TW-1:0]     tmr_val;
   logic [DATA_W-1:0] din_s;

   // read-back synchronizer, depth chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign din_s = dat_i;
   end else begin : g_sync
      logic [DATA_W-1:0] sr_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sr_q[i] <= '0;
         end else begin
            sr_q[0] <= dat_i;
            for (int i = 1; i < SYNC_STAGES; i++) sr_q[i] <= sr_q[i-1];
         end
      end
      assign din_s = sr_q[SYNC_STAGES-1];
   end

   assign match = (din_s == byte_q);

   // next-state
   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:   if (start_i) st_d = ST_SETTLE;
         ST_SETTLE: if (tmr_zero) st_d = ST_CLR;
         ST_CLR:    if (tmr_zero) st_d = ST_VDDUP;
         ST_VDDUP:  if (tmr_zero) st_d = ST_VPPUP;
         ST_VPPUP:  if (tmr_zero) st_d = ST_INH;
         ST_INH:    if (tmr_zero) st_d = ST_FETCH;
         ST_FETCH:  if (src_valid_i) st_d = ST_DSET;
         ST_DSET:   if (tmr_zero) st_d = ST_WR;
         ST_WR:     if (tmr_zero) st_d = ST_WHLD;
         ST_WHLD:   if (tmr_zero) st_d = extra_q ? ST_STEP : ST_VFY;
         ST_VFY:    if (tmr_zero) st_d = (!match && tries_q == MAX_T) ? ST_FCLR : ST_DSET;
         ST_STEP:   if (step_fin) st_d = last_q ? ST_FCLR : ST_FETCH;
         ST_FCLR:   if (tmr_zero) st_d = ST_VPPDN;
         ST_VPPDN:  if (tmr_zero) st_d = ST_VDDDN;
         ST_VDDDN:  if (tmr_zero) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   // interval for the state being entered
   always_comb begin
      tmr_load = (st_d != st_q) && is_timed(st_d);
      case (st_d)
         ST_SETTLE: tmr_val = TW'(SETTLE_CYC - 1);
         ST_WR:     tmr_val = extra_q ? (TW'(WR_CYC) * TW'(tries_q)) - TW'(1)
                                      : TW'(WR_CYC - 1);
         default:   tmr_val = TW'(SETUP_CYC - 1);
      endcase
   end

   assign step_go = (st_d == ST_STEP) && (st_q != ST_STEP);

   pv_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
   );

   pv_stepper #(.HALF(CYC_US)) u_step (
      .clk(clk), .rst_n(rst_n), .go(step_go), .xclk(xclk_o), .fin(step_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pins_q  <= pins_of(ST_IDLE);
         byte_q  <= '0;
         last_q  <= 1'b0;
         extra_q <= 1'b0;
         tries_q <= '0;
         addr_q  <= '0;
         fail_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         pins_q <= pins_of(st_d);
         done_q <= (st_q == ST_VDDDN) && (st_d == ST_IDLE);
         if (st_q == ST_IDLE && start_i) begin
            fail_q <= 1'b0;
            addr_q <= '0;
         end
         if (st_q == ST_FETCH && src_valid_i) begin
            byte_q  <= src_data_i;
            last_q  <= src_last_i;
            tries_q <= '0;
            extra_q <= 1'b0;
         end
         if (st_q == ST_DSET && tmr_zero && !extra_q) tries_q <= tries_q + 1'b1;
         if (st_q == ST_VFY && tmr_zero) begin
            if (match)                    extra_q <= 1'b1;
            else if (tries_q == MAX_T)    fail_q  <= 1'b1;
         end
         if (st_q == ST_STEP && step_fin && !last_q) addr_q <= addr_q + 1'b1;
      end
   end

   assign src_ready_o = (st_q == ST_FETCH);
   assign mode_o      = pins_q.mode;
   assign dat_oe_o    = pins_q.oe;
   assign vdd_prog_o  = pins_q.vdd;
   assign vpp_prog_o  = pins_q.vpp;
   assign dat_o       = byte_q;
   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = done_q;
   assign fail_o      = fail_q;
   assign fail_addr_o = addr_q;

   // R1
   idle_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!vdd_prog_o && !vpp_prog_o && !dat_oe_o && !xclk_o));
   // R3
   rail_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_prog_o |-> vdd_prog_o);
   // R4
   wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == PM_WRITE) |-> dat_oe_o);
   // R4
   wr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == PM_WRITE) |=> (mode_o == PM_WRITE || mode_o == PM_INHIBIT));
   // R5
   vfy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == PM_VERIFY) |-> !dat_oe_o);
   // R7
   step_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xclk_o |-> (mode_o == PM_INHIBIT && !dat_oe_o));
   // R8
   tries_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q <= MAX_T);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && mode_o == PM_IDLE));

endmodule

// File: tb/prom_pv_seq_tb.sv
`timescale 1ns/1ps
module prom_pv_seq_tb;
   localparam int CLK_HZ = 1_000_000, WR_US = 20, SETTLE_US = 10, SETUP_US = 2;
   localparam int MAX_TRIES = 4, SYNC = 1, DW = 8, AW = 15;
   localparam logic [3:0] M_CLR = 4'b0101, M_WR = 4'b1110, M_VFY = 4'b1100,
                          M_INH = 4'b1101;
   // {need writes, byte, expected ordinary writes}
   localparam int NV = 5;
   localparam logic [23:0] VEC [NV] = '{
      {8'd1, 8'hA5, 8'd1},
      {8'd3, 8'h3C, 8'd3},
      {8'd2, 8'hFF, 8'd1},   // erased value matches at once (R10)
      {8'd4, 8'h0F, 8'd4},   // needs exactly the limit
      {8'd2, 8'hC3, 8'd2}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, src_valid_i = 1'b0, src_last_i = 1'b0;
   logic [DW-1:0] src_data_i = '0, dat_o, dat_i;
   logic src_ready_o, xclk_o, dat_oe_o, vdd_prog_o, vpp_prog_o;
   logic busy_o, done_o, fail_o;
   logic [3:0] mode_o;
   logic [AW-1:0] fail_addr_o;

   always #2 clk = ~clk;   // 250 MHz

   prom_pv_seq #(.CLK_HZ(CLK_HZ), .WR_US(WR_US), .SETTLE_US(SETTLE_US),
      .SETUP_US(SETUP_US), .MAX_TRIES(MAX_TRIES), .SYNC_STAGES(SYNC),
      .DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_valid_i(src_valid_i),
      .src_data_i(src_data_i), .src_last_i(src_last_i), .src_ready_o(src_ready_o),
      .mode_o(mode_o), .xclk_o(xclk_o), .dat_o(dat_o), .dat_oe_o(dat_oe_o),
      .dat_i(dat_i), .vdd_prog_o(vdd_prog_o), .vpp_prog_o(vpp_prog_o),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o));

   // ---------------- pin-level memory model ----------------
   int need [16], wcnt [16], first_len [16], last_len [16];
   logic [7:0] mem [16];
   logic [3:0] maddr = '0;
   int ecnt = 0, cur_len = 0;
   logic [3:0] pm = '0;
   logic px = 1'b0;

   assign dat_i = (mode_o == M_VFY && !dat_oe_o) ? mem[maddr] : 8'h00;

   always @(posedge clk) begin
      pm <= mode_o;
      px <= xclk_o;
      if (mode_o == M_CLR) begin
         maddr <= '0;
         ecnt  <= 0;
      end else if (xclk_o && !px) begin
         if (ecnt == 3) begin maddr <= maddr + 4'd1; ecnt <= 0; end
         else ecnt <= ecnt + 1;
      end
      if (mode_o == M_WR) begin
         if (pm != M_WR) begin
            wcnt[maddr] <= wcnt[maddr] + 1;
            cur_len <= 1;
            if (wcnt[maddr] + 1 >= need[maddr])
               mem[maddr] <= dat_oe_o ? dat_o : 8'hEE;
         end else cur_len <= cur_len + 1;
      end else if (pm == M_WR) begin
         last_len[maddr] <= cur_len;
         if (first_len[maddr] == 0) first_len[maddr] <= cur_len;
      end
   end

   // ---------------- supply / timing monitor ----------------
   int cyc = 0, t_start = 0, t_clr = 0, t_vdd = 0, t_vpp = 0, t_vppf = 0, t_vddf = 0;
   int rail_viol = 0;
   logic clr_seen = 1'b0, pv = 1'b0, pp = 1'b0;
   logic [3:0] mode_vdd_up = '0, mode_vpp_dn = '0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      pv <= vdd_prog_o;
      pp <= vpp_prog_o;
      if (start_i && !busy_o) begin t_start <= cyc; clr_seen <= 1'b0; end
      if (mode_o == M_CLR && !vdd_prog_o && !clr_seen) begin t_clr <= cyc; clr_seen <= 1'b1; end
      if (vdd_prog_o && !pv) begin t_vdd <= cyc; mode_vdd_up <= mode_o; end
      if (vpp_prog_o && !pp) t_vpp <= cyc;
      if (!vpp_prog_o && pp) begin t_vppf <= cyc; mode_vpp_dn <= mode_o; end
      if (!vdd_prog_o && pv) t_vddf <= cyc;
      if (vpp_prog_o && !vdd_prog_o) rail_viol <= rail_viol + 1;
   end

   // ---------------- checking ----------------
   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int a = 0; a < 16; a++) begin
         mem[a] = 8'hFF; wcnt[a] = 0; first_len[a] = 0; last_len[a] = 0; need[a] = 1;
      end
   endtask

   task automatic kick();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic feed(input logic [7:0] b, input bit last);
      int w;
      @(negedge clk);
      src_valid_i = 1'b1; src_data_i = b; src_last_i = last;
      w = 0;
      while (!src_ready_o && w < 20000) begin @(negedge clk); w++; end
      if (w >= 20000) chk(1'b0, "R7 source accept timeout", w, 0);
      @(negedge clk);
      src_valid_i = 1'b0; src_last_i = 1'b0;
   endtask

   task automatic wait_done();
      int w;
      w = 0;
      while (!done_o && w < 40000) begin @(negedge clk); w++; end
      chk(done_o === 1'b1, "R9 done pulse", int'(done_o), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      model_clear();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!vdd_prog_o && !vpp_prog_o, "R1 supplies off", int'(vdd_prog_o), 0);
      chk(!dat_oe_o && !xclk_o && !busy_o && !src_ready_o, "R1 quiet pins", int'(busy_o), 0);
      chk(mode_o == 4'b0000, "R1 idle mode", int'(mode_o), 0);

      // ---- session 1: vector table ----
      for (int i = 0; i < NV; i++) need[i] = int'(VEC[i][23:16]);
      kick();
      chk(busy_o === 1'b1, "R9 busy during session", int'(busy_o), 1);
      for (int i = 0; i < NV; i++) feed(VEC[i][15:8], i == NV - 1);
      wait_done();
      chk(fail_o == 1'b0, "R8 no fail on good stream", int'(fail_o), 0);
      chk(mode_o == 4'b0000 && !busy_o, "R9 back to idle", int'(mode_o), 0);
      for (int i = 0; i < NV; i++) begin
         int t;
         t = int'(VEC[i][7:0]);
         chk(mem[i] == VEC[i][15:8], "R5 stored byte", int'(mem[i]), int'(VEC[i][15:8]));
         chk(wcnt[i] == t + 1, "R5 write count", wcnt[i], t + 1);
         chk(first_len[i] == WR_US, "R4 base write length", first_len[i], WR_US);
         chk(last_len[i] == WR_US * t, "R6 extra write length", last_len[i], WR_US * t);
      end
      chk(wcnt[NV] == 0, "R9 last flag stops session", wcnt[NV], 0);
      // R2 / R3 timing
      chk(t_clr - t_start == SETTLE_US + 1, "R2 settle before clear", t_clr - t_start, SETTLE_US + 1);
      chk(t_vdd - t_clr == SETUP_US, "R2 clear before supply", t_vdd - t_clr, SETUP_US);
      chk(mode_vdd_up == M_CLR, "R3 clear at supply rise", int'(mode_vdd_up), int'(M_CLR));
      chk(t_vpp - t_vdd == SETUP_US, "R3 high supply after low", t_vpp - t_vdd, SETUP_US);
      chk(t_vddf - t_vppf == SETUP_US, "R3 high supply drops first", t_vddf - t_vppf, SETUP_US);
      chk(mode_vpp_dn == M_CLR, "R3 clear at supply fall", int'(mode_vpp_dn), int'(M_CLR));
      chk(rail_viol == 0, "R3 rail order", rail_viol, 0);

      // ---- session 2: byte 1 exceeds the retry limit ----
      model_clear();
      need[1] = MAX_TRIES + 5;
      kick();
      feed(8'h11, 1'b0);
      feed(8'h5A, 1'b1);
      wait_done();
      chk(fail_o == 1'b1, "R8 fail flag", int'(fail_o), 1);
      chk(fail_addr_o == AW'(1), "R8 fail address", int'(fail_addr_o), 1);
      chk(wcnt[1] == MAX_TRIES, "R8 writes capped", wcnt[1], MAX_TRIES);
      chk(last_len[1] == WR_US, "R8 no extra write on abort", last_len[1], WR_US);
      chk(wcnt[0] == 2 && mem[0] == 8'h11, "R7 first byte completed", wcnt[0], 2);
      chk(!vdd_prog_o && !vpp_prog_o, "R8 supplies off after abort", int'(vpp_prog_o), 0);

      // ---- session 3: fail cleared by a new start ----
      model_clear();
      kick();
      chk(fail_o == 1'b0, "R8 fail cleared on start", int'(fail_o), 0);
      feed(8'h77, 1'b1);
      wait_done();
      chk(mem[0] == 8'h77 && last_len[0] == WR_US, "R10 single write byte", last_len[0], WR_US);
      chk(fail_o == 1'b0, "R8 clean session", int'(fail_o), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule